// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device. After software has launched a program or erase operation, a single start pulse hands the job of deciding when that operation has finished to this block. It reads the device status byte repeatedly through a simple request/acknowledge bus port. In each byte it looks at one chosen toggle bit and at the time-limit bit, which is bit 5.

A pair of reads in which the chosen bit holds steady means the operation is complete. A changing bit together with a low bit 5 leads to a further pair of reads. A changing bit together with a high bit 5 leads to one confirmation pair. If the bit still moves in that pair, the block writes the reset command so that the device returns to array reads, and it reports failure. An optional limit on the number of read pairs acts as a watchdog. A yield input lets the host leave the poll early. A later start then always begins again from the first read.

Top module: `toggle_poll_ctl`

## Requirements
- R1: While reset is active and right after it, `busReq`, `busWe`, `busy`, `done` and `fail` are all low.
- R2: After `start`, the block reads the status byte twice. If bit number `toggleSel` (0 to 7) is equal in both bytes, it sets `done=1` and `fail=0` and issues no write.
- R3: If the selected bit differs between the two reads and bit 5 of the second byte is 0, the block makes a new pair of reads under the same rules.
- R4: If the selected bit differs and bit 5 of the second byte is 1, the block makes exactly two more reads. If the selected bit is equal in those two reads, the result is success (`done=1`, `fail=0`) with no write.
- R5: If the selected bit still differs in the confirmation pair, the block performs one bus write (`busWe=1`) of data 0xF0. After that write is acknowledged it sets `done=1` and `fail=1`.
- R6: When `maxPolls` is nonzero, the pair that would be toggling pair number `maxPolls` with bit 5 low ends the poll. The block then performs the 0xF0 write and sets `done=1`, `fail=1`. A value of 0 sets no limit.
- R7: A high `yieldReq` during any read phase returns the block to idle with `done=0` and `fail=0`, and any read that has not been acknowledged is discarded. The next `start` begins again with the first read of a fresh pair.
- R8: `done` and `fail` hold their value until the next accepted `start`, which clears both on the following clock. A `start` pulse while `busy` is high has no effect on the result.
- R9: `busReq` stays high until `busAck`, and each acknowledge completes exactly one transaction. The outcome flags change only on a cycle that follows an acknowledge.

Note: bit 5 is the time-limit bit in every status byte. `done` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (ignored while busy) |
| toggleSel | input | 3 | Index of the toggle bit in the status byte |
| maxPolls | input | 8 | Limit on toggling read pairs, 0 = none |
| yieldReq | input | 1 | Abandon the poll during a read phase |
| busReq | output | 1 | Bus transaction request, held until acknowledged |
| busWe | output | 1 | 1 = write transaction, 0 = read |
| busWData | output | 8 | Write data (0xF0 reset command) |
| busAck | input | 1 | Transaction acknowledge |
| busRData | input | 8 | Read data, valid with busAck |
| busy | output | 1 | Poll in progress |
| done | output | 1 | Poll finished (sticky) |
| fail | output | 1 | Poll finished with failure (sticky) |

## Verification
The block captures a read byte on the clock edge where it sees `busAck`. The bus model drives `busAck` on falling edges and always leaves it low for one cycle between transactions, so a pair of reads takes four clocks. `done` and `fail` settle on the same rising edge that consumes the last acknowledge. `start` and `yieldReq` take effect on the first rising edge after they are driven. The bench therefore drives and samples 3 ns after a rising edge, and it reads results only when `done` is high or `busy` has dropped. It then compares the number of reads, the number of writes and the write data against vectors worked out by hand.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;

  localparam logic [7:0] RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,   // first read of a pair
    ST_RD_B,   // second read of a pair
    ST_RC_A,   // first confirmation read (bit 5 seen high)
    ST_RC_B,   // second confirmation read
    ST_RST     // reset command write
  } pollState_e;

  typedef struct packed {
    logic clearAll;
    logic captureFirst;
    logic incPoll;
    logic setDone;
    logic setFail;
  } pollStrobe_t;

endpackage

// File: rtl/toggle_poll_dp.sv
module toggle_poll_dp
  import toggle_poll_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 8,
  parameter int LIMIT_BIT = 5,
  localparam int SEL_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strobe,
  input  logic [DATA_W-1:0] busRData,
  input  logic [SEL_W-1:0]  toggleSel,
  input  logic [CNT_W-1:0]  maxPolls,
  output logic              bitChanged,
  output logic              timeBit,
  output logic              limitHit,
  output logic              done,
  output logic              fail
);

  logic             firstBit;
  logic [CNT_W-1:0] pollCnt;
  logic             selBit;
  logic [CNT_W:0]   nextCnt;

  assign selBit     = busRData[toggleSel];
  assign bitChanged = selBit != firstBit;
  assign timeBit    = busRData[LIMIT_BIT];
  assign nextCnt    = {1'b0, pollCnt} + 1'b1;
  assign limitHit   = (maxPolls != '0) && (nextCnt >= {1'b0, maxPolls});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstBit <= 1'b0;
      pollCnt  <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      if (strobe.clearAll) begin
        pollCnt <= '0;
        done    <= 1'b0;
        fail    <= 1'b0;
      end
      if (strobe.captureFirst) firstBit <= selBit;
      if (strobe.incPoll)      pollCnt  <= nextCnt[CNT_W-1:0];
      if (strobe.setDone)      done     <= 1'b1;
      if (strobe.setFail)      fail     <= 1'b1;
    end
  end

endmodule

// File: rtl/toggle_poll_fsm.sv
module toggle_poll_fsm
  import toggle_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        yieldReq,
  input  logic        busAck,
  input  logic        bitChanged,
  input  logic        timeBit,
  input  logic        limitHit,
  output pollStrobe_t strobe,
  output logic        busReq,
  output logic        busWe,
  output logic        busy
);

  pollState_e state, stateNext;

  assign busReq = state != ST_IDLE;
  assign busWe  = state == ST_RST;
  assign busy   = state != ST_IDLE;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext       = ST_RD_A;
          strobe.clearAll = 1'b1;
        end
      end
      ST_RD_A, ST_RC_A: begin
        if (yieldReq) begin
          stateNext = ST_IDLE;
        end else if (busAck) begin
          strobe.captureFirst = 1'b1;
          stateNext = (state == ST_RD_A) ? ST_RD_B : ST_RC_B;
        end
      end
      ST_RD_B: begin
        if (yieldReq) begin
          stateNext = ST_IDLE;
        end else if (busAck) begin
          if (!bitChanged) begin
            strobe.setDone = 1'b1;
            stateNext      = ST_IDLE;
          end else if (timeBit) begin
            stateNext = ST_RC_A;
          end else if (limitHit) begin
            stateNext = ST_RST;
          end else begin
            strobe.incPoll = 1'b1;
            stateNext      = ST_RD_A;
          end
        end
      end
      ST_RC_B: begin
        if (yieldReq) begin
          stateNext = ST_IDLE;
        end else if (busAck) begin
          if (!bitChanged) begin
            strobe.setDone = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            stateNext = ST_RST;
          end
        end
      end
      ST_RST: begin
        if (busAck) begin
          strobe.setDone = 1'b1;
          strobe.setFail = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/toggle_poll_ctl.sv
module toggle_poll_ctl
  import toggle_poll_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 8,
  parameter int LIMIT_BIT = 5,
  localparam int SEL_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SEL_W-1:0]  toggleSel,
  input  logic [CNT_W-1:0]  maxPolls,
  input  logic              yieldReq,
  output logic              busReq,
  output logic              busWe,
  output logic [DATA_W-1:0] busWData,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRData,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  pollStrobe_t strobe;
  logic        bitChanged;
  logic        timeBit;
  logic        limitHit;

  assign busWData = busWe ? DATA_W'(RESET_CMD) : '0;

  toggle_poll_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .yieldReq   (yieldReq),
    .busAck     (busAck),
    .bitChanged (bitChanged),
    .timeBit    (timeBit),
    .limitHit   (limitHit),
    .strobe     (strobe),
    .busReq     (busReq),
    .busWe      (busWe),
    .busy       (busy)
  );

  toggle_poll_dp #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .LIMIT_BIT (LIMIT_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busRData   (busRData),
    .toggleSel  (toggleSel),
    .maxPolls   (maxPolls),
    .bitChanged (bitChanged),
    .timeBit    (timeBit),
    .limitHit   (limitHit),
    .done       (done),
    .fail       (fail)
  );

endmodule

// File: rtl/toggle_poll_checker.sv
module toggle_poll_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              yieldReq,
  input logic              busReq,
  input logic              busWe,
  input logic [DATA_W-1:0] busWData,
  input logic              busAck,
  input logic              busy,
  input logic              done,
  input logic              fail
);

  // R5: a write is always the reset command inside a request
  a_r5_write_is_reset_cmd: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (busReq && busWData == DATA_W'(8'hF0)));

  // R9: request held until acknowledged (no yield during a write)
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && (busWe || !yieldReq)) |=> busReq);

  // R9: outcome appears only after an acknowledge
  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busAck));

  // R8: flags sticky while no start
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R5: failure always comes with done
  a_r5_fail_implies_done: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done);

  // R8: done and busy exclusive
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R7: yield in a read phase leaves busy low on the next cycle
  a_r7_yield_idles: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !busWe && yieldReq) |=> !busy);

endmodule

bind toggle_poll_ctl toggle_poll_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .yieldReq (yieldReq),
  .busReq   (busReq),
  .busWe    (busWe),
  .busWData (busWData),
  .busAck   (busAck),
  .busy     (busy),
  .done     (done),
  .fail     (fail)
);

// File: tb/test_toggle_poll_ctl.sv
module test_toggle_poll_ctl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [2:0] toggleSel = 3'd6;
  logic [7:0] maxPolls = 8'd0;
  logic       yieldReq = 1'b0;
  logic       busReq, busWe, busy, done, fail;
  logic [7:0] busWData;
  logic       busAck = 1'b0;
  logic [7:0] busRData = 8'h00;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [7:0][7:0] script = '0;
  int idx = 0;
  int rdCount = 0;
  int wrCount = 0;
  logic [7:0] lastW = 8'h00;

  typedef struct packed {
    logic [7:0][7:0] rd;     // rd[7] is the first read
    logic [2:0]      sel;
    logic [7:0]      maxP;
    logic [3:0]      expRd;
    logic [1:0]      expWr;
    logic            expFail;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R2 steady on first pair
    '{ {8'h40,8'h40,48'h0},                     3'd6, 8'd0, 4'd2, 2'd0, 1'b0 },
    // R3 toggle with bit5 low, second pair steady
    '{ {8'h00,8'h40,8'h40,8'h40,32'h0},         3'd6, 8'd0, 4'd4, 2'd0, 1'b0 },
    // R4 bit5 high, confirmation steady
    '{ {8'h00,8'h60,8'h60,8'h60,32'h0},         3'd6, 8'd0, 4'd4, 2'd0, 1'b0 },
    // R5 bit5 high, confirmation still toggling
    '{ {8'h00,8'h60,8'h20,8'h60,32'h0},         3'd6, 8'd0, 4'd4, 2'd1, 1'b1 },
    // R3 toggle bit at index 2, two toggling pairs then steady
    '{ {8'h04,8'h00,8'h04,8'h00,8'h00,8'h00,16'h0}, 3'd2, 8'd0, 4'd6, 2'd0, 1'b0 },
    // R6 limit of 2 toggling pairs
    '{ {8'h00,8'h40,8'h00,8'h40,32'h0},         3'd6, 8'd2, 4'd4, 2'd1, 1'b1 },
    // R2 only bit 2 moves while bit 6 is selected
    '{ {8'h04,8'h00,48'h0},                     3'd6, 8'd0, 4'd2, 2'd0, 1'b0 }
  };

  toggle_poll_ctl i_toggle_poll_ctl (
    .clk(clk), .rstN(rstN), .start(start), .toggleSel(toggleSel),
    .maxPolls(maxPolls), .yieldReq(yieldReq), .busReq(busReq), .busWe(busWe),
    .busWData(busWData), .busAck(busAck), .busRData(busRData),
    .busy(busy), .done(done), .fail(fail)
  );

  always #5 clk = ~clk;

  // bus model: acknowledges on falling edges, one idle cycle between transfers
  always @(negedge clk) begin
    if (busReq && !busAck && !yieldReq) begin
      busAck = 1'b1;
      if (busWe) begin
        wrCount++;
        lastW = busWData;
      end else begin
        busRData = (idx < 8) ? script[7-idx] : 8'h00;
        idx++;
        rdCount++;
      end
    end else begin
      busAck = 1'b0;
    end
  end

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadScript(input logic [7:0][7:0] s);
    script = s;
    idx = 0;
    rdCount = 0;
    wrCount = 0;
    lastW = 8'h00;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic waitEnd();
    int guard = 0;
    while (!done && busy && guard < 500) begin
      tick();
      guard++;
    end
  endtask

  initial begin
    // R1 reset state
    repeat (3) tick();
    check("R1 busReq", busReq, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 fail", fail, 0);
    rstN = 1'b1;
    tick();
    check("R1 busReq after reset", busReq, 0);

    for (int v = 0; v < NV; v++) begin
      loadScript(VECS[v].rd);
      toggleSel = VECS[v].sel;
      maxPolls  = VECS[v].maxP;
      pulseStart();
      check("R8 start clears done", done, 0);
      waitEnd();
      check("R2/R3/R4/R5/R6 done", done, 1);
      check("R2/R3/R4/R5/R6 fail", fail, VECS[v].expFail);
      check("R2/R3/R4/R5/R6 reads", rdCount, VECS[v].expRd);
      check("R5/R6 writes", wrCount, VECS[v].expWr);
      if (VECS[v].expWr != 0) check("R5 write data", lastW, 8'hF0);
      repeat (2) tick();
    end

    // R8 sticky flags
    repeat (5) tick();
    check("R8 done sticky", done, 1);
    check("R8 fail sticky", fail, 0);

    // R8 start while busy ignored
    loadScript({8'h00,8'h40,8'h40,8'h40,32'h0});
    toggleSel = 3'd6;
    maxPolls  = 8'd0;
    pulseStart();
    while (rdCount < 1) tick();
    tick();
    pulseStart();
    waitEnd();
    check("R8 busy start ignored done", done, 1);
    check("R8 busy start ignored reads", rdCount, 4);

    // R7 yield during read phase, then restart from first read
    loadScript({8'h00,8'h00,48'h0});
    pulseStart();
    while (rdCount < 1) tick();
    yieldReq = 1'b1;
    tick();
    yieldReq = 1'b0;
    check("R7 busy after yield", busy, 0);
    check("R7 done after yield", done, 0);
    check("R7 busReq after yield", busReq, 0);
    check("R7 reads before yield", rdCount, 1);
    loadScript({8'h40,8'h40,48'h0});
    pulseStart();
    waitEnd();
    check("R7 restart done", done, 1);
    check("R7 restart fail", fail, 0);
    check("R7 restart reads", rdCount, 2);

    // R6 limit of 1 ends on the first toggling pair; R9 one read per ack
    loadScript({8'h00,8'h40,48'h0});
    maxPolls = 8'd1;
    pulseStart();
    waitEnd();
    check("R6 limit1 fail", fail, 1);
    check("R9 limit1 reads", rdCount, 2);
    check("R9 limit1 writes", wrCount, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule